// File: doc/BRIEF.md
# Linked Display List Walker

At the start of every video frame this block walks a chain of per-scanline entries held in system memory. It produces one descriptor for each displayed line. Each entry gives the line's pixel start address and the pointer to the next entry. The low bits of that pointer carry flags. One flag flips a persistent cursor-on state. The others say whether the following entry is an extended one with a 32-bit side record in front of it. A side record is either a control record or a palette record. Control records reload the latched cursor settings, and those settings then apply to every later line.

Entries are read over a simple 16-bit read port. The block holds a request with its byte address until the memory acknowledges it, and the data arrives in the same cycle as the acknowledge. Descriptors leave on a valid/ready stream. A frame-start pulse restarts the walk at any time. The block issues no further memory read until the current descriptor has been accepted. After the last of the 306 lines it stays idle until the next frame start.

Top module: `dlist_walker`

## Requirements
- R1: From reset, `mem_req` and `dl_valid` stay low until the first `frame_start` pulse.
- R2: The cycle after `frame_start` is high, the block requests byte address 0x00B8. The walk restarts from there even in the middle of a frame. The cursor flag, the extended-entry state and the latched cursor settings are all cleared. The first entry of a frame is always plain.
- R3: For an entry at pointer P, the word at P is the line's pixel address and is output on `dl_pix_addr`. The word at P+2 is the link word. P is read before P+2.
- R4: `dl_cursor` for a line equals the cursor flag of the previous line XOR bit 0 of this line's link word. The flag starts at 0 each frame and persists from line to line.
- R5: Link bit 1 set: the next entry is extended and is a control record if bit 2 is 0 or a palette record if bit 2 is 1. Its pointer is (link AND NOT 7) + 4. Link bit 1 clear: the next entry is plain and its pointer is link AND NOT 3.
- R6: For an extended entry, the block reads P-4 (low half of the record) and then P-2 (high half) before P and P+2. `dl_kind` is 0 for plain, 1 for control and 2 for palette. `dl_aux` is {high, low} for extended entries and 0 for plain ones.
- R7: On a control line, the cursor settings come from the record: colour from bits 3:0, graphic mode from bit 4, pixel-in-octet from bits 7:5 and octet position from bits 14:8. That line's descriptor already shows them. Plain and palette lines repeat the settings of the line before.
- R8: Each frame yields exactly 306 descriptors, with `dl_line` running from 0 to 305. After the last one is accepted there is no read until the next `frame_start`.
- R9: While `dl_valid` is high and `dl_ready` is low, every descriptor field holds steady. `mem_req` is never high together with `dl_valid`.
- R10: `mem_req` and `mem_addr` stay steady until `mem_ack`, and the data is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that restarts the walk |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge; data valid this cycle |
| mem_rdata | input | 16 | Read data |
| dl_valid | output | 1 | Descriptor valid |
| dl_ready | input | 1 | Descriptor accepted when high with valid |
| dl_line | output | 9 | Line index within the frame |
| dl_pix_addr | output | 16 | Pixel data start address of the line |
| dl_cursor | output | 1 | Cursor-active flag of the line |
| dl_kind | output | 2 | Entry kind: 0 plain, 1 control, 2 palette |
| dl_aux | output | 32 | Side record of an extended entry, else 0 |
| dl_cur_color | output | 4 | Latched cursor colour |
| dl_cur_graphic | output | 1 | Latched cursor mode (1 graphic) |
| dl_cur_pixel | output | 3 | Latched pixel position in octet |
| dl_cur_octet | output | 7 | Latched octet position in line |

## Verification
The bench generates lists whose link flags are plain only, random, or extended only. For each list it predicts the exact read order and each line's descriptor. A design that read the side-record halves in the wrong order, or that dropped the +4 adjustment, would fetch wrong addresses on the very next entry. A design that XORed the cursor toggle in one line late, or that let palette records overwrite cursor settings, would show a mismatched `dl_cursor` or cursor field on some line. A frame restarted mid-walk checks that stale cursor and extended state are discarded. The run also checks that the 306th line ends the frame without a stray read, and random stalls on both the read port and the descriptor stream catch descriptors that drift or reads that overlap an unaccepted descriptor.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_AUX_LO = 3'd1,
    ST_AUX_HI = 3'd2,
    ST_PIX    = 3'd3,
    ST_LINK   = 3'd4,
    ST_EMIT   = 3'd5
  } dlw_state_e;

  typedef enum logic [1:0] {
    REC_PLAIN = 2'd0,
    REC_CTRL  = 2'd1,
    REC_PAL   = 2'd2
  } dlw_rec_e;

  typedef struct packed {
    logic [3:0] color;
    logic       graphic;
    logic [2:0] pixel;
    logic [6:0] octet;
  } dlw_cursor_t;

  // cursor settings live in the low 15 bits of a control record
  function automatic dlw_cursor_t dlw_unpack_cursor(input logic [14:0] rec);
    dlw_cursor_t c;
    c.color   = rec[3:0];
    c.graphic = rec[4];
    c.pixel   = rec[7:5];
    c.octet   = rec[14:8];
    return c;
  endfunction

endpackage

// File: rtl/dlw_rst_sync.sv
module dlw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dlw_link_decode.sv
module dlw_link_decode
  import dlw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] link,
  output logic [ADDR_W-1:0] next_ptr,
  output dlw_rec_e          next_kind,
  output logic              cursor_flip
);

  localparam logic [ADDR_W-1:0] EXT_SKIP = ADDR_W'(4);

  always_comb begin
    cursor_flip = link[0];
    if (link[1]) begin
      next_ptr  = {link[ADDR_W-1:3], 3'b000} + EXT_SKIP;
      next_kind = link[2] ? REC_PAL : REC_CTRL;
    end else begin
      next_ptr  = {link[ADDR_W-1:2], 2'b00};
      next_kind = REC_PLAIN;
    end
  end

endmodule

// File: rtl/dlw_cursor_track.sv
module dlw_cursor_track
  import dlw_pkg::*;
#(
  parameter int AUX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             commit,
  input  logic             flip,
  input  dlw_rec_e         kind,
  input  logic [AUX_W-1:0] aux,
  output logic             line_flag,
  output dlw_cursor_t      line_cursor
);

  logic        flag_q, flag_d, flag_en;
  dlw_cursor_t cur_q, cur_d;
  logic        cur_en;

  // values the current line presents
  always_comb begin
    line_flag   = flag_q ^ flip;
    line_cursor = (kind == REC_CTRL) ? dlw_unpack_cursor(aux[14:0]) : cur_q;
  end

  // next-state
  always_comb begin
    flag_en = 1'b0;
    flag_d  = flag_q;
    cur_en  = 1'b0;
    cur_d   = cur_q;
    if (clr) begin
      flag_en = 1'b1;
      flag_d  = 1'b0;
      cur_en  = 1'b1;
      cur_d   = '0;
    end else if (commit) begin
      flag_en = 1'b1;
      flag_d  = line_flag;
      cur_en  = 1'b1;
      cur_d   = line_cursor;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cur_q  <= '0;
    end else begin
      if (flag_en) flag_q <= flag_d;
      if (cur_en)  cur_q  <= cur_d;
    end
  end

endmodule

// File: rtl/dlw_fetch_seq.sv
module dlw_fetch_seq
  import dlw_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 16,
  parameter int              NUM_LINES = 306,
  parameter int              LINE_W    = 9,
  parameter logic [ADDR_W-1:0] START_PTR = 16'h00B8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                accept,
  input  logic [ADDR_W-1:0]   next_ptr,
  input  dlw_rec_e            next_kind,
  output logic                emit,
  output dlw_rec_e            cur_kind,
  output logic [DATA_W-1:0]   pix_word,
  output logic [DATA_W-1:0]   link_word,
  output logic [2*DATA_W-1:0] aux_word,
  output logic [LINE_W-1:0]   line_idx
);

  localparam logic [ADDR_W-1:0] STEP2     = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP4     = ADDR_W'(4);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(NUM_LINES - 1);

  dlw_state_e          state_q, state_d;
  logic [ADDR_W-1:0]   ptr_q, ptr_d;
  dlw_rec_e            kind_q, kind_d;
  logic [LINE_W-1:0]   line_q, line_d;
  logic [DATA_W-1:0]   lo_q, hi_q, pix_q, link_q;
  logic                ptr_en, kind_en, line_en;
  logic                lo_en, hi_en, pix_en, link_en;

  // request port
  always_comb begin
    mem_req = (state_q == ST_AUX_LO) || (state_q == ST_AUX_HI) ||
              (state_q == ST_PIX)    || (state_q == ST_LINK);
    unique case (state_q)
      ST_AUX_LO: mem_addr = ptr_q - STEP4;
      ST_AUX_HI: mem_addr = ptr_q - STEP2;
      ST_LINK:   mem_addr = ptr_q + STEP2;
      default:   mem_addr = ptr_q;
    endcase
  end

  // next-state
  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    kind_d  = kind_q;
    line_d  = line_q;
    ptr_en  = 1'b0;
    kind_en = 1'b0;
    line_en = 1'b0;
    lo_en   = 1'b0;
    hi_en   = 1'b0;
    pix_en  = 1'b0;
    link_en = 1'b0;
    if (frame_start) begin
      state_d = ST_PIX;
      ptr_d   = START_PTR;
      kind_d  = REC_PLAIN;
      line_d  = '0;
      ptr_en  = 1'b1;
      kind_en = 1'b1;
      line_en = 1'b1;
    end else begin
      unique case (state_q)
        ST_AUX_LO: if (mem_ack) begin
          lo_en   = 1'b1;
          state_d = ST_AUX_HI;
        end
        ST_AUX_HI: if (mem_ack) begin
          hi_en   = 1'b1;
          state_d = ST_PIX;
        end
        ST_PIX: if (mem_ack) begin
          pix_en  = 1'b1;
          state_d = ST_LINK;
        end
        ST_LINK: if (mem_ack) begin
          link_en = 1'b1;
          state_d = ST_EMIT;
        end
        ST_EMIT: if (accept) begin
          ptr_en  = 1'b1;
          ptr_d   = next_ptr;
          kind_en = 1'b1;
          kind_d  = next_kind;
          if (line_q == LAST_LINE) begin
            state_d = ST_IDLE;
          end else begin
            line_en = 1'b1;
            line_d  = line_q + LINE_W'(1);
            state_d = (next_kind == REC_PLAIN) ? ST_PIX : ST_AUX_LO;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      kind_q  <= REC_PLAIN;
      line_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      pix_q   <= '0;
      link_q  <= '0;
    end else begin
      state_q <= state_d;
      if (ptr_en)  ptr_q  <= ptr_d;
      if (kind_en) kind_q <= kind_d;
      if (line_en) line_q <= line_d;
      if (lo_en)   lo_q   <= mem_rdata;
      if (hi_en)   hi_q   <= mem_rdata;
      if (pix_en)  pix_q  <= mem_rdata;
      if (link_en) link_q <= mem_rdata;
    end
  end

  assign emit      = (state_q == ST_EMIT);
  assign cur_kind  = kind_q;
  assign pix_word  = pix_q;
  assign link_word = link_q;
  assign aux_word  = {hi_q, lo_q};
  assign line_idx  = line_q;

endmodule

// File: rtl/dlist_walker.sv
module dlist_walker
  import dlw_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter int                NUM_LINES = 306,
  parameter logic [ADDR_W-1:0] START_PTR = 16'h00B8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_start,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata,
  output logic        dl_valid,
  input  logic        dl_ready,
  output logic [8:0]  dl_line,
  output logic [15:0] dl_pix_addr,
  output logic        dl_cursor,
  output logic [1:0]  dl_kind,
  output logic [31:0] dl_aux,
  output logic [3:0]  dl_cur_color,
  output logic        dl_cur_graphic,
  output logic [2:0]  dl_cur_pixel,
  output logic [6:0]  dl_cur_octet
);

  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int AUX_W  = 2 * DATA_W;

  logic                rst_sync_n;
  logic                emit, accept, flip;
  dlw_rec_e            cur_kind, next_kind;
  logic [ADDR_W-1:0]   next_ptr, addr_w;
  logic [DATA_W-1:0]   pix_word, link_word;
  logic [AUX_W-1:0]    aux_word;
  logic [LINE_W-1:0]   line_idx;
  logic                line_flag;
  dlw_cursor_t         line_cursor;

  dlw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign accept = emit & dl_ready;

  dlw_fetch_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W),
    .START_PTR (START_PTR)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_start (frame_start),
    .mem_req     (mem_req),
    .mem_addr    (addr_w),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .accept      (accept),
    .next_ptr    (next_ptr),
    .next_kind   (next_kind),
    .emit        (emit),
    .cur_kind    (cur_kind),
    .pix_word    (pix_word),
    .link_word   (link_word),
    .aux_word    (aux_word),
    .line_idx    (line_idx)
  );

  dlw_link_decode #(
    .ADDR_W (ADDR_W)
  ) u_link (
    .link        (link_word),
    .next_ptr    (next_ptr),
    .next_kind   (next_kind),
    .cursor_flip (flip)
  );

  dlw_cursor_track #(
    .AUX_W (AUX_W)
  ) u_cursor (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .clr         (frame_start),
    .commit      (accept),
    .flip        (flip),
    .kind        (cur_kind),
    .aux         (aux_word),
    .line_flag   (line_flag),
    .line_cursor (line_cursor)
  );

  assign mem_addr       = addr_w;
  assign dl_valid       = emit;
  assign dl_line        = line_idx;
  assign dl_pix_addr    = pix_word;
  assign dl_cursor      = line_flag;
  assign dl_kind        = cur_kind;
  assign dl_aux         = (cur_kind == REC_PLAIN) ? '0 : aux_word;
  assign dl_cur_color   = line_cursor.color;
  assign dl_cur_graphic = line_cursor.graphic;
  assign dl_cur_pixel   = line_cursor.pixel;
  assign dl_cur_octet   = line_cursor.octet;

endmodule

// File: rtl/dlist_walker_chk.sv
module dlist_walker_chk #(
  parameter int          NUM_LINES = 306,
  parameter logic [15:0] START_PTR = 16'h00B8
) (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        frame_start,
  input logic        mem_req,
  input logic [15:0] mem_addr,
  input logic        mem_ack,
  input logic        dl_valid,
  input logic        dl_ready,
  input logic [8:0]  dl_line,
  input logic [15:0] dl_pix_addr,
  input logic        dl_cursor,
  input logic [1:0]  dl_kind,
  input logic [31:0] dl_aux,
  input logic [3:0]  dl_cur_color,
  input logic        dl_cur_graphic,
  input logic [2:0]  dl_cur_pixel,
  input logic [6:0]  dl_cur_octet
);

  logic        started_q, have_q;
  logic [14:0] last_q;
  logic [14:0] now_set;

  assign now_set = {dl_cur_octet, dl_cur_pixel, dl_cur_graphic, dl_cur_color};

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      started_q <= 1'b0;
      have_q    <= 1'b0;
      last_q    <= '0;
    end else begin
      if (frame_start) started_q <= 1'b1;
      if (frame_start) begin
        have_q <= 1'b1;
        last_q <= '0;
      end else if (dl_valid && dl_ready) begin
        last_q <= now_set;
      end
    end
  end

  assert_idle_until_start_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !started_q |-> (!mem_req && !dl_valid));

  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_start |=> (mem_req && mem_addr == START_PTR && !dl_valid));

  assert_plain_aux_zero_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dl_valid && dl_kind == 2'd0) |-> (dl_aux == 32'd0));

  assert_kind_legal_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dl_valid |-> (dl_kind != 2'd3));

  assert_cursor_carry_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dl_valid && dl_kind != 2'd1 && have_q) |-> (now_set == last_q));

  assert_line_range_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dl_valid |-> (dl_line < 9'(NUM_LINES)));

  assert_desc_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dl_valid && !dl_ready && !frame_start) |=>
      (dl_valid && $stable(dl_pix_addr) && $stable(dl_aux) && $stable(dl_cursor) &&
       $stable(dl_kind) && $stable(dl_line) && $stable(now_set)));

  assert_no_read_overlap_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_req && dl_valid));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && !mem_ack && !frame_start) |=> (mem_req && $stable(mem_addr)));

endmodule

bind dlist_walker dlist_walker_chk #(
  .NUM_LINES (NUM_LINES),
  .START_PTR (START_PTR)
) chk_i (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .frame_start    (frame_start),
  .mem_req        (mem_req),
  .mem_addr       (mem_addr),
  .mem_ack        (mem_ack),
  .dl_valid       (dl_valid),
  .dl_ready       (dl_ready),
  .dl_line        (dl_line),
  .dl_pix_addr    (dl_pix_addr),
  .dl_cursor      (dl_cursor),
  .dl_kind        (dl_kind),
  .dl_aux         (dl_aux),
  .dl_cur_color   (dl_cur_color),
  .dl_cur_graphic (dl_cur_graphic),
  .dl_cur_pixel   (dl_cur_pixel),
  .dl_cur_octet   (dl_cur_octet)
);

// File: tb/dlist_walker_tb_top.sv
module dlist_walker_tb_top;

  localparam int          LINES = 306;
  localparam logic [15:0] HEAD  = 16'h00B8;
  localparam int          WDOG  = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_start;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack;
  logic [15:0] mem_rdata;
  logic        dl_valid;
  logic        dl_ready;
  logic [8:0]  dl_line;
  logic [15:0] dl_pix_addr;
  logic        dl_cursor;
  logic [1:0]  dl_kind;
  logic [31:0] dl_aux;
  logic [3:0]  dl_cur_color;
  logic        dl_cur_graphic;
  logic [2:0]  dl_cur_pixel;
  logic [6:0]  dl_cur_octet;

  always #4 clk = ~clk;

  dlist_walker dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dl_valid(dl_valid), .dl_ready(dl_ready), .dl_line(dl_line),
    .dl_pix_addr(dl_pix_addr), .dl_cursor(dl_cursor), .dl_kind(dl_kind), .dl_aux(dl_aux),
    .dl_cur_color(dl_cur_color), .dl_cur_graphic(dl_cur_graphic),
    .dl_cur_pixel(dl_cur_pixel), .dl_cur_octet(dl_cur_octet)
  );

  typedef struct {
    int          line;
    logic [15:0] pix;
    logic        cur;
    logic [1:0]  kind;
    logic [31:0] aux;
    logic [14:0] cset;
  } exp_desc_t;

  typedef struct {
    logic [15:0] addr;
    int          why;   // 0 frame head, 1 side record, 2 entry words
  } exp_rd_t;

  logic [15:0] mem [bit [15:0]];
  exp_desc_t   dq[$];
  exp_rd_t     aq[$];

  int checks = 0, fails = 0, cyc = 0;
  int fs_req = 0, fs_seen = 0, acc_cnt = 0;
  int ack_pct = 100, rdy_pct = 100;
  bit wd_hit = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] rd(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  // list builder: mode 0 plain links only, 1 random flags, 2 extended links only
  task automatic build_list(input int mode);
    logic [15:0] p, base, nv;
    logic [2:0]  fl;
    bit          ext;
    mem.delete();
    p   = HEAD;
    ext = 0;
    for (int i = 0; i < LINES; i++) begin
      if (ext) begin
        mem[p - 16'd4] = 16'($urandom);
        mem[p - 16'd2] = 16'($urandom);
      end
      base = 16'h1000 + 16'(i * 16);
      fl   = 3'($urandom_range(7));
      if (mode == 0) fl[1] = 1'b0;
      if (mode == 2) fl[1] = 1'b1;
      nv = base | {13'd0, fl};
      mem[p]         = 16'($urandom);
      mem[p + 16'd2] = nv;
      if (fl[1]) begin p = base + 16'd4; ext = 1; end
      else       begin p = nv & 16'hFFFC; ext = 0; end
    end
  endtask

  // behavioural walk of the list, straight from the requirements
  task automatic predict();
    logic [15:0] p, nv;
    logic [1:0]  kind;
    logic [31:0] aux;
    logic        flag;
    logic [14:0] cset;
    dq.delete();
    aq.delete();
    p = HEAD; kind = 2'd0; flag = 0; cset = '0;
    for (int i = 0; i < LINES; i++) begin
      aux = 32'd0;
      if (kind != 2'd0) begin
        aq.push_back('{p - 16'd4, 1});
        aq.push_back('{p - 16'd2, 1});
        aux = {rd(p - 16'd2), rd(p - 16'd4)};
      end
      aq.push_back('{p, (i == 0) ? 0 : 2});
      aq.push_back('{p + 16'd2, 2});
      nv   = rd(p + 16'd2);
      flag = flag ^ nv[0];
      if (kind == 2'd1) cset = aux[14:0];
      dq.push_back('{i, rd(p), flag, kind, aux, cset});
      if (nv[1]) begin
        p    = {nv[15:3], 3'b000} + 16'd4;
        kind = nv[2] ? 2'd2 : 2'd1;
      end else begin
        p    = {nv[15:2], 2'b00};
        kind = 2'd0;
      end
    end
  endtask

  // driver and comparator, once per clock on the falling edge
  always @(negedge clk) begin
    exp_desc_t e;
    cyc++;
    if (cyc > WDOG && !wd_hit) begin
      wd_hit = 1;
      chk(0, "watchdog", 32'(cyc), 32'(WDOG));
    end
    if (rst_n !== 1'b1) begin
      frame_start = 0; mem_ack = 0; mem_rdata = '0; dl_ready = 0;
    end else if (fs_seen != fs_req) begin
      fs_seen     = fs_req;
      frame_start = 1; mem_ack = 0; dl_ready = 0;
      predict();
      acc_cnt = 0;
    end else begin
      frame_start = 0;
      if (mem_req && dl_valid) chk(0, "R9 read overlaps descriptor", 32'(mem_addr), 32'd0);
      mem_ack = 0;
      if (mem_req) begin
        if (aq.size() == 0) chk(0, "R8 read after last line", 32'(mem_addr), 32'd0);
        else if ($urandom_range(99) < ack_pct) begin
          // R10: data returned in the acknowledge cycle for the held address
          mem_ack   = 1;
          mem_rdata = rd(mem_addr);
          chk(mem_addr == aq[0].addr,
              aq[0].why == 0 ? "R2 head address" : (aq[0].why == 1 ? "R6 side record address" : "R3 entry address"),
              32'(mem_addr), 32'(aq[0].addr));
          void'(aq.pop_front());
        end
      end
      dl_ready = ($urandom_range(99) < rdy_pct);
      if (dl_valid && dl_ready) begin
        if (dq.size() == 0) chk(0, "R8 extra descriptor", 32'(dl_line), 32'd0);
        else begin
          e = dq.pop_front();
          chk(dl_line == 9'(e.line), "R8 line index", 32'(dl_line), 32'(e.line));
          chk(dl_pix_addr == e.pix, "R3 pixel address", 32'(dl_pix_addr), 32'(e.pix));
          chk(dl_cursor == e.cur, "R4 cursor flag", 32'(dl_cursor), 32'(e.cur));
          chk(dl_kind == e.kind, "R5 entry kind", 32'(dl_kind), 32'(e.kind));
          chk(dl_aux == e.aux, "R6 side record", dl_aux, e.aux);
          chk({dl_cur_octet, dl_cur_pixel, dl_cur_graphic, dl_cur_color} == e.cset,
              "R7 cursor settings", 32'({dl_cur_octet, dl_cur_pixel, dl_cur_graphic, dl_cur_color}),
              32'(e.cset));
          acc_cnt++;
        end
      end
    end
  end

  task automatic run_frame(input int ackp, input int rdyp);
    ack_pct = ackp;
    rdy_pct = rdyp;
    @(posedge clk);
    fs_req++;
    while (!wd_hit && (fs_seen != fs_req || dq.size() != 0)) @(posedge clk);
    repeat (30) @(posedge clk);
    chk(acc_cnt == LINES, "R8 descriptors per frame", 32'(acc_cnt), 32'(LINES));
    chk(aq.size() == 0, "R8 reads per frame", 32'(aq.size()), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(!mem_req, "R1 no read before frame start", 32'(mem_req), 32'd0);
    chk(!dl_valid, "R1 no descriptor before frame start", 32'(dl_valid), 32'd0);

    build_list(0);
    run_frame(100, 100);
    build_list(1);
    run_frame(50, 60);
    build_list(2);
    run_frame(70, 30);
    build_list(1);
    run_frame(100, 100);   // same list twice: R2 clears cursor state between frames
    run_frame(35, 80);

    // R2: restart in the middle of a frame
    build_list(1);
    ack_pct = 60; rdy_pct = 50;
    @(posedge clk);
    fs_req++;
    repeat (700) @(posedge clk);
    run_frame(60, 50);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule